// File: doc/BRIEF.md
# Bursty Arrival Pattern Generator

This block produces synthetic packet arrivals for every virtual output queue of an N by N input-queued switch. It gives one arrival bit per queue per time-slot. Each queue owns a two-state modulating chain with a quiet state and a busy state. At every time-slot the chain may change state, and then an arrival is drawn with the probability that belongs to the state the chain is now in. Because the arrival rate moves between two levels, the traffic comes in bursts. The switch model under test consumes these bits as its offered load.

All probabilities are programmable 16-bit unsigned fractions. Each queue has its own 32-bit linear feedback shift register, seeded from a configuration input at reset. The generator moves forward only when the time-slot strobe is high, so its outputs hold steady between strobes. If both level fractions are set to the same value, the output is plain independent Bernoulli arrivals.

Top module: `mmb_traffic_gen`

## Requirements
- R1: `arrive_o` is registered and changes only on the clock edge where `slot_i` is high. The new value is visible in the cycle after that edge. On every other edge all bits keep their value.
- R2: While `rst` is high, at a rising clock edge, three things happen. Every chain enters the quiet state. `arrive_o` clears to zero. The random register of queue i loads `seed_i[32*i+31:32*i]`, or the value 1 if that slice is zero.
- R3: Each queue's random register is a 32-bit Galois shift register. One step works as follows: remember bit 0, shift right by one, then XOR with 32'h80200003 if the remembered bit was 1. The register takes exactly 32 steps on every strobe edge, and none on other edges.
- R4: The flip draw is bits [15:0] of the queue's register before the strobe advance. The chain changes state when this draw is strictly less than `flip_prob_i`.
- R5: The arrival draw is bits [31:16] of the same pre-advance register. The arrival bit is 1 when this draw is strictly less than `rate_busy_i` if the chain's new state is busy, or strictly less than `rate_quiet_i` if the new state is quiet.
- R6: The comparisons are strict. A fraction of 0 never fires. A fraction of 16'hFFFF fires for every draw except 16'hFFFF. With `flip_prob_i` equal to 0, every chain stays in its current state.
- R7: Every queue uses its own register and chain. With equal quiet and busy fractions, each bit is an independent Bernoulli draw of that fraction. Queue index i maps to bit i of `arrive_o`, which serves input port i/N and output port i mod N.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; loads the seeds |
| slot_i | input | 1 | Time-slot strobe; the generator advances only when it is high |
| flip_prob_i | input | 16 | Per-slot chance that a chain changes state (fraction of 65536) |
| rate_quiet_i | input | 16 | Arrival chance in the quiet state |
| rate_busy_i | input | 16 | Arrival chance in the busy state |
| seed_i | input | NUM_PORTS*NUM_PORTS*32 | Register seed for each queue, 32 bits per queue |
| arrive_o | output | NUM_PORTS*NUM_PORTS | Arrival bit for each queue in the current slot |

## Verification
The first pattern sets the flip chance to zero and the quiet rate to zero. This shows whether the chains really start quiet and stay there: any arrival means a wrong reset state or a spurious flip. The second pattern sets the flip chance to its maximum, with a zero quiet rate and a half busy rate. Arrivals then fall on alternate slots, which reveals errors in the flip draw, in the state used for the arrival draw, and in the slice each draw takes. The third pattern uses equal levels and tests the plain Bernoulli case. The fourth uses bursty settings with idle cycles between strobes, so it tests both the hold behaviour and the per-queue register advance. One seed is zero, so the substitute seed is covered.

// File: rtl/mmb_pkg.sv
package mmb_pkg;
  localparam int RNG_W = 32;
  localparam int FRAC_W = 16;
  localparam logic [RNG_W-1:0] RNG_POLY = 32'h80200003;
  localparam logic [RNG_W-1:0] RNG_SAFE = 32'h00000001;

  // one strobe = RNG_W single steps, so every slot sees fresh bits
  function automatic logic [RNG_W-1:0] rng_advance(input logic [RNG_W-1:0] s);
    logic [RNG_W-1:0] v;
    v = s;
    for (int k = 0; k < RNG_W; k++) begin
      v = v[0] ? ((v >> 1) ^ RNG_POLY) : (v >> 1);
    end
    return v;
  endfunction
endpackage

// File: rtl/mmb_rng.sv
module mmb_rng
  import mmb_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             step_i,
  input  logic [RNG_W-1:0] seed_i,
  output logic [RNG_W-1:0] state_o
);
  logic [RNG_W-1:0] state_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= (seed_i == '0) ? RNG_SAFE : seed_i;
    end else if (step_i) begin
      state_q <= rng_advance(state_q);
    end
  end

  assign state_o = state_q;

  AST_RNG_NONZERO: assert property (@(posedge clk) disable iff (rst)
    state_q != '0); // R3

  AST_RNG_HOLD: assert property (@(posedge clk) disable iff (rst)
    !step_i |=> $stable(state_q)); // R3
endmodule

// File: rtl/mmb_chain.sv
module mmb_chain #(
  parameter int FRAC_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              slot_i,
  input  logic [FRAC_W-1:0] draw_flip_i,
  input  logic [FRAC_W-1:0] draw_arr_i,
  input  logic [FRAC_W-1:0] flip_prob_i,
  input  logic [FRAC_W-1:0] rate_quiet_i,
  input  logic [FRAC_W-1:0] rate_busy_i,
  output logic              arrive_o
);
  logic busy_q;
  logic arrive_q;
  logic flip;
  logic busy_nxt;
  logic [FRAC_W-1:0] level;

  always_comb begin
    flip     = draw_flip_i < flip_prob_i;
    busy_nxt = busy_q ^ flip;
    level    = busy_nxt ? rate_busy_i : rate_quiet_i;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q   <= 1'b0;
      arrive_q <= 1'b0;
    end else if (slot_i) begin
      busy_q   <= busy_nxt;
      arrive_q <= draw_arr_i < level;
    end
  end

  assign arrive_o = arrive_q;

  AST_NO_FLIP: assert property (@(posedge clk) disable iff (rst)
    (slot_i && flip_prob_i == '0) |=> $stable(busy_q)); // R6

  AST_ZERO_RATE: assert property (@(posedge clk) disable iff (rst)
    (slot_i && rate_quiet_i == '0 && rate_busy_i == '0) |=> !arrive_q); // R6

  AST_FULL_RATE: assert property (@(posedge clk) disable iff (rst)
    (slot_i && rate_quiet_i == '1 && rate_busy_i == '1 && draw_arr_i != '1) |=> arrive_q); // R5
endmodule

// File: rtl/mmb_traffic_gen.sv
module mmb_traffic_gen
  import mmb_pkg::*;
#(
  parameter int NUM_PORTS = 2,
  localparam int NUM_Q = NUM_PORTS * NUM_PORTS
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   slot_i,
  input  logic [FRAC_W-1:0]      flip_prob_i,
  input  logic [FRAC_W-1:0]      rate_quiet_i,
  input  logic [FRAC_W-1:0]      rate_busy_i,
  input  logic [NUM_Q*RNG_W-1:0] seed_i,
  output logic [NUM_Q-1:0]       arrive_o
);
  for (genvar g = 0; g < NUM_Q; g++) begin : g_queue
    logic [RNG_W-1:0] rng;

    mmb_rng u_rng (
      .clk     (clk),
      .rst     (rst),
      .step_i  (slot_i),
      .seed_i  (seed_i[g*RNG_W +: RNG_W]),
      .state_o (rng)
    );

    mmb_chain #(.FRAC_W(FRAC_W)) u_chain (
      .clk          (clk),
      .rst          (rst),
      .slot_i       (slot_i),
      .draw_flip_i  (rng[FRAC_W-1:0]),
      .draw_arr_i   (rng[RNG_W-1 -: FRAC_W]),
      .flip_prob_i  (flip_prob_i),
      .rate_quiet_i (rate_quiet_i),
      .rate_busy_i  (rate_busy_i),
      .arrive_o     (arrive_o[g])
    );
  end

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    !slot_i |=> $stable(arrive_o)); // R1
endmodule

// File: tb/mmb_traffic_gen_tb.sv
module mmb_traffic_gen_tb;
  localparam int NP = 2;
  localparam int NQ = NP * NP;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic slot = 1'b0;
  logic [15:0] flip_p = '0, r_quiet = '0, r_busy = '0;
  logic [NQ*32-1:0] seeds;
  logic [NQ-1:0] arr;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  logic [31:0] m_rng [NQ];
  bit          m_busy [NQ];
  logic [NQ-1:0] m_arr;

  always #10 clk = ~clk;

  mmb_traffic_gen #(.NUM_PORTS(NP)) u_dut (
    .clk(clk), .rst(rst), .slot_i(slot), .flip_prob_i(flip_p),
    .rate_quiet_i(r_quiet), .rate_busy_i(r_busy), .seed_i(seeds), .arrive_o(arr)
  );

  function automatic logic [31:0] ref_step32(input logic [31:0] s);
    logic [31:0] v = s;
    for (int k = 0; k < 32; k++) begin
      if (v[0]) v = (v >> 1) ^ 32'h80200003;
      else      v = v >> 1;
    end
    return v;
  endfunction

  task automatic check(input string tag, input logic [NQ-1:0] got, input logic [NQ-1:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: arrive_o=%b expected %b at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < NQ; i++) begin
      m_rng[i]  = (seeds[i*32 +: 32] == 0) ? 32'h1 : seeds[i*32 +: 32];
      m_busy[i] = 1'b0;
    end
    m_arr = '0;
  endtask

  // one cycle; s=1 is a strobe; model follows R3-R5, checked after the edge
  task automatic cycle(input bit s, input string tag);
    logic [NQ-1:0] prev;
    @(negedge clk);
    slot = s;
    prev = m_arr;
    @(posedge clk);
    if (s) begin
      for (int i = 0; i < NQ; i++) begin
        logic [15:0] df, da, lv;
        df = m_rng[i][15:0];
        da = m_rng[i][31:16];
        if (df < flip_p) m_busy[i] = !m_busy[i];
        lv = m_busy[i] ? r_busy : r_quiet;
        m_arr[i] = (da < lv);
        m_rng[i] = ref_step32(m_rng[i]);
      end
    end
    #1;
    if (s) check(tag, arr, m_arr);
    else   check("R1 hold between strobes", arr, prev);
  endtask

  initial begin
    seeds = {32'h0, 32'h13579BDF, 32'hDEADBEEF, 32'h0BADF00D}; // queue 3 seed zero
    repeat (3) @(posedge clk);
    #1;
    check("R2 reset clears arrivals", arr, '0);
    @(negedge clk);
    rst = 1'b0;
    model_reset();

    // no flips, quiet rate zero: chains must remain quiet (R2, R6)
    flip_p = 16'h0000; r_quiet = 16'h0000; r_busy = 16'hFFFF;
    for (int n = 0; n < 40; n++) cycle(1'b1, "R6 zero flip keeps quiet");
    check("R2 quiet start means no arrivals", arr, '0);

    // flip nearly always: alternate busy/quiet (R4, R5)
    flip_p = 16'hFFFF; r_quiet = 16'h0000; r_busy = 16'h8000;
    for (int n = 0; n < 200; n++) cycle(1'b1, "R4 R5 flip and arrival draws");

    // equal levels: plain Bernoulli (R7)
    flip_p = 16'h4000; r_quiet = 16'h4000; r_busy = 16'h4000;
    for (int n = 0; n < 200; n++) cycle(1'b1, "R7 equal levels Bernoulli");

    // full rates: fires except on draw FFFF (R6)
    r_quiet = 16'hFFFF; r_busy = 16'hFFFF;
    for (int n = 0; n < 50; n++) cycle(1'b1, "R6 full fraction");

    // bursty settings with idle cycles between strobes (R1, R3)
    flip_p = 16'h4CCC; r_quiet = 16'h1999; r_busy = 16'hB333;
    for (int n = 0; n < 300; n++) begin
      cycle(1'b1, "R3 R5 bursty slot");
      for (int k = 0; k < (n % 3); k++) cycle(1'b0, "R1");
    end

    // reset mid-run reloads seeds and returns to quiet (R2)
    @(negedge clk); rst = 1'b1; slot = 1'b0;
    @(posedge clk); #1;
    check("R2 mid-run reset clears", arr, '0);
    @(negedge clk); rst = 1'b0;
    model_reset();
    for (int n = 0; n < 100; n++) cycle(1'b1, "R2 R3 reseeded sequence");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #5_000_000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule